// File: doc/BRIEF.md
# I2C Slave Controller with 7/10-bit Address Matching

This block is the target side of a two-wire serial bus. It watches the clock and data pads through synchronizers and recognises bus framing: start, repeated start and stop. It compares the address a master sends with a programmable own address, which may be 7 or 10 bits wide. When the address is its own, it acknowledges and then either accepts data bytes from the master or sends bytes back to it.

Incoming bits collect in a shift register. Each finished byte moves into a holding buffer, so software has a whole byte time to read a byte before the next one arrives. The slave drives both lines open-drain: its outputs only ask for a line to be pulled low. It can keep the clock line low to pause the master until software gives a release pulse. Software learns of bus events through a one-cycle event pulse, and of lost bytes through a separate error pulse.

Top module: `i2c_addr_slave`

## Requirements
- R1: In 7-bit mode (`wide_mode`=0), the slave acknowledges a first byte whose bits [7:1] equal `own_addr[6:0]`. Bit 0 is the direction: 0 means the master writes, 1 means the master reads. To acknowledge, the slave pulls SDA low through the ninth clock, and it drops the pull only after that clock's falling edge. A byte that does not match gets no acknowledge, and the slave ignores everything until the next START.
- R2: In 10-bit mode, a header byte `11110 a9 a8 0` is acknowledged, where a9 and a8 are `own_addr[9:8]`. The next byte must equal `own_addr[7:0]`. The address is counted as matched, and reported, only when that second byte also matches. A wrong second byte gets no acknowledge.
- R3: In 10-bit mode, a header with direction bit 1 is acknowledged only if a full 10-bit match has happened since the last STOP, normally followed by a repeated START. That header opens a read. Without such an earlier match the header gets no acknowledge.
- R4: Data written by the master arrives MSB first. When a byte completes and the buffer is empty, the byte is copied to `rx_byte`, `rx_full` goes to 1 and the byte is acknowledged. While `rx_full` is 1 and `rx_take` is low, `rx_byte` does not change.
- R5: `slave_evt` is a one-cycle pulse. It fires on each completed address match, on each byte copied into the buffer, and on each transmitted byte that the master acknowledges.
- R6: If a byte completes while `rx_full` is 1, the byte is dropped. `rx_byte` keeps its old value, the byte gets no acknowledge, `overflow` goes to 1, and `err_evt` pulses for one cycle. A pulse on `rx_take` clears both `rx_full` and `overflow`.
- R7: The slave holds SCL low at two points: after it acknowledges a received data byte, and before each byte it transmits. The hold starts at the falling edge that ends the acknowledge clock and lasts until a `scl_free` pulse. A `scl_free` pulse while the slave is not holding SCL has no effect.
- R8: Read data is taken from `tx_byte` at the moment the slave releases SCL, and is sent MSB first. SDA is left free for the master's acknowledge bit. If the master does not acknowledge, the transfer ends and SDA stays free until the next START.
- R9: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A STOP returns the slave to idle and releases both lines. A repeated START begins a new address phase.
- R10: After reset, both line pulls are off, `rx_full` and `overflow` are 0, and neither event pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Clock line level read from the pad |
| sda_in | input | 1 | Data line level read from the pad |
| scl_drive_low | output | 1 | 1 pulls the clock line low |
| sda_drive_low | output | 1 | 1 pulls the data line low |
| own_addr | input | 10 | Own slave address; 7-bit mode uses bits [6:0] |
| wide_mode | input | 1 | 1 selects 10-bit addressing |
| scl_free | input | 1 | Pulse that ends a clock hold |
| tx_byte | input | 8 | Byte to send in a read transfer |
| rx_byte | output | 8 | Receive holding buffer |
| rx_full | output | 1 | Buffer holds an unread byte |
| rx_take | input | 1 | Pulse: software has read the buffer |
| overflow | output | 1 | A byte was dropped because the buffer was full |
| slave_evt | output | 1 | One-cycle slave event pulse |
| err_evt | output | 1 | One-cycle error pulse |

## Verification
The checker tests several properties on every cycle:
- each event pulse lasts exactly one cycle;
- an error pulse always comes with `overflow` set and the buffer full;
- a full buffer keeps its byte until it is taken;
- a clock hold never ends without a release pulse or a bus condition;
- the data pull is only switched on while the synchronized clock is low;
- a STOP leaves both lines released.

Only the bench's master-driven scenarios can show the protocol results: which bytes are acknowledged in 7-bit and 10-bit modes, the refused 10-bit read header, the bytes received and transmitted, and the point where a hold starts and stops.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
   localparam int BYTE_W = 8;
   localparam int ADDR_W = 10;
   localparam int CNT_W  = 4;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_HDR,
      PH_LOW,
      PH_RX,
      PH_TX,
      PH_SKIP
   } phase_t;
endpackage

// File: rtl/i2c_pad_sense.sv
module i2c_pad_sense #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_pad,
   input  logic sda_pad,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_cond,
   output logic stop_cond
);
   localparam int TOP = SYNC_STAGES - 1;

   logic [TOP:0] scl_ff, sda_ff;
   logic         scl_d, sda_d;

   initial begin
      assert (SYNC_STAGES >= 2) else $error("i2c_pad_sense: SYNC_STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_d  <= 1'b1;
         sda_d  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[TOP-1:0], scl_pad};
         sda_ff <= {sda_ff[TOP-1:0], sda_pad};
         scl_d  <= scl_ff[TOP];
         sda_d  <= sda_ff[TOP];
      end
   end

   assign scl_lvl    = scl_ff[TOP];
   assign sda_lvl    = sda_ff[TOP];
   assign scl_rise   = scl_lvl & ~scl_d;
   assign scl_fall   = ~scl_lvl & scl_d;
   assign start_cond = scl_lvl & scl_d & sda_d & ~sda_lvl;
   assign stop_cond  = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
   import i2c_slv_pkg::*;
#(
   parameter bit WIDE_EN = 1'b1
) (
   input  logic [BYTE_W-1:1] hdr,
   input  logic [BYTE_W-1:0] full_byte,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              wide_req,
   output logic              short_hit,
   output logic              long_hdr_hit,
   output logic              long_low_hit,
   output logic              wide_eff
);
   localparam logic [4:0] LONG_TAG = 5'b11110;

   assign short_hit = (hdr == own_addr[6:0]);

   generate
      if (WIDE_EN) begin : g_wide
         assign wide_eff     = wide_req;
         assign long_hdr_hit = (hdr[7:3] == LONG_TAG) && (hdr[2:1] == own_addr[9:8]);
         assign long_low_hit = (full_byte == own_addr[7:0]);
      end else begin : g_narrow
         assign wide_eff     = 1'b0;
         assign long_hdr_hit = 1'b0;
         assign long_low_hit = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/i2c_rx_hold.sv
module i2c_rx_hold
   import i2c_slv_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [BYTE_W-1:0] push_data,
   input  logic              take,
   output logic [BYTE_W-1:0] data,
   output logic              full,
   output logic              ovf,
   output logic              drop
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data <= '0;
         full <= 1'b0;
         ovf  <= 1'b0;
         drop <= 1'b0;
      end else begin
         drop <= push & full;
         if (push && !full) begin
            data <= push_data;
            full <= 1'b1;
         end else if (take) begin
            full <= 1'b0;
         end
         if (push && full)
            ovf <= 1'b1;
         else if (take)
            ovf <= 1'b0;
      end
   end
endmodule

// File: rtl/i2c_addr_slave.sv
module i2c_addr_slave
   import i2c_slv_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit WIDE_EN     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              scl_drive_low,
   output logic              sda_drive_low,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              wide_mode,
   input  logic              scl_free,
   input  logic [BYTE_W-1:0] tx_byte,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              rx_full,
   input  logic              rx_take,
   output logic              overflow,
   output logic              slave_evt,
   output logic              err_evt
);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
   localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);

   logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_c, stop_c;

   i2c_pad_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_pad    (scl_in),
      .sda_pad    (sda_in),
      .scl_lvl    (scl_lvl),
      .sda_lvl    (sda_lvl),
      .scl_rise   (scl_rise),
      .scl_fall   (scl_fall),
      .start_cond (start_c),
      .stop_cond  (stop_c)
   );

   phase_t             phase_q, next_q;
   logic [CNT_W-1:0]   bit_q;
   logic [BYTE_W-2:0]  sh_q, tx_q;
   logic               in_ack_q, ack_drv_q, tx_drv_q, ack_pend_q;
   logic               stretch_q, str_pend_q, wide_hit_q, mack_q;

   logic [BYTE_W-1:0]  nb;
   logic               counting, byte_done, mack_evt;
   logic               short_hit, long_hdr_hit, long_low_hit, wide_eff;

   assign nb        = {sh_q, sda_lvl};
   assign counting  = (phase_q == PH_HDR) || (phase_q == PH_LOW) ||
                      (phase_q == PH_RX)  || (phase_q == PH_TX);
   assign byte_done = scl_rise && counting && !in_ack_q && (bit_q == LAST_BIT);
   assign mack_evt  = scl_rise && in_ack_q && (phase_q == PH_TX) && !sda_lvl;

   i2c_addr_match #(.WIDE_EN(WIDE_EN)) u_match (
      .hdr          (nb[BYTE_W-1:1]),
      .full_byte    (nb),
      .own_addr     (own_addr),
      .wide_req     (wide_mode),
      .short_hit    (short_hit),
      .long_hdr_hit (long_hdr_hit),
      .long_low_hit (long_low_hit),
      .wide_eff     (wide_eff)
   );

   logic drop_p;

   // byte-complete decision
   logic   dec_ack, dec_str, dec_evt, dec_push, dec_wset, dec_wclr;
   phase_t dec_next;

   always_comb begin
      dec_ack  = 1'b0;
      dec_str  = 1'b0;
      dec_evt  = 1'b0;
      dec_push = 1'b0;
      dec_wset = 1'b0;
      dec_wclr = 1'b0;
      dec_next = PH_SKIP;
      case (phase_q)
         PH_HDR: begin
            if (!wide_eff) begin
               if (short_hit) begin
                  dec_ack  = 1'b1;
                  dec_evt  = 1'b1;
                  dec_str  = nb[0];
                  dec_next = nb[0] ? PH_TX : PH_RX;
               end
            end else if (long_hdr_hit) begin
               if (!nb[0]) begin
                  dec_ack  = 1'b1;
                  dec_wclr = 1'b1;
                  dec_next = PH_LOW;
               end else if (wide_hit_q) begin
                  dec_ack  = 1'b1;
                  dec_evt  = 1'b1;
                  dec_str  = 1'b1;
                  dec_next = PH_TX;
               end
            end
         end
         PH_LOW: begin
            if (long_low_hit) begin
               dec_ack  = 1'b1;
               dec_evt  = 1'b1;
               dec_wset = 1'b1;
               dec_next = PH_RX;
            end
         end
         PH_RX: begin
            dec_push = 1'b1;
            dec_ack  = !rx_full;
            dec_evt  = !rx_full;
            dec_str  = !rx_full;
            dec_next = PH_RX;
         end
         PH_TX:   dec_next = PH_TX;
         default: dec_next = PH_SKIP;
      endcase
   end

   i2c_rx_hold u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (byte_done & dec_push),
      .push_data (nb),
      .take      (rx_take),
      .data      (rx_byte),
      .full      (rx_full),
      .ovf       (overflow),
      .drop      (drop_p)
   );

   // main bit engine
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q    <= PH_IDLE;
         next_q     <= PH_IDLE;
         bit_q      <= '0;
         sh_q       <= '0;
         tx_q       <= '0;
         in_ack_q   <= 1'b0;
         ack_drv_q  <= 1'b0;
         tx_drv_q   <= 1'b0;
         ack_pend_q <= 1'b0;
         stretch_q  <= 1'b0;
         str_pend_q <= 1'b0;
         mack_q     <= 1'b0;
      end else if (start_c || stop_c) begin
         phase_q   <= start_c ? PH_HDR : PH_IDLE;
         bit_q     <= '0;
         in_ack_q  <= 1'b0;
         ack_drv_q <= 1'b0;
         tx_drv_q  <= 1'b0;
         stretch_q <= 1'b0;
      end else begin
         if (stretch_q && scl_free) begin
            stretch_q <= 1'b0;
            if (phase_q == PH_TX) begin
               tx_q     <= tx_byte[BYTE_W-2:0];
               tx_drv_q <= ~tx_byte[BYTE_W-1];
            end
         end
         if (scl_rise && counting && !in_ack_q) begin
            bit_q <= bit_q + 1'b1;
            sh_q  <= nb[BYTE_W-2:0];
            if (bit_q == LAST_BIT) begin
               ack_pend_q <= dec_ack;
               str_pend_q <= dec_str;
               next_q     <= dec_next;
            end
         end
         if (scl_rise && in_ack_q && (phase_q == PH_TX))
            mack_q <= !sda_lvl;
         if (scl_fall && counting) begin
            if (!in_ack_q && (bit_q == ACK_SLOT)) begin
               in_ack_q  <= 1'b1;
               ack_drv_q <= ack_pend_q && (phase_q != PH_TX);
               tx_drv_q  <= 1'b0;
            end else if (in_ack_q) begin
               in_ack_q  <= 1'b0;
               ack_drv_q <= 1'b0;
               bit_q     <= '0;
               if (phase_q == PH_TX) begin
                  if (mack_q) stretch_q <= 1'b1;
                  else        phase_q   <= PH_SKIP;
               end else begin
                  phase_q   <= next_q;
                  stretch_q <= str_pend_q;
               end
            end else if ((phase_q == PH_TX) && (bit_q != '0)) begin
               tx_drv_q <= ~tx_q[BYTE_W-2];
               tx_q     <= {tx_q[BYTE_W-3:0], 1'b0};
            end
         end
      end
   end

   // 10-bit match memory, lives until STOP
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         wide_hit_q <= 1'b0;
      else if (stop_c || (byte_done && dec_wclr))
         wide_hit_q <= 1'b0;
      else if (byte_done && dec_wset)
         wide_hit_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slave_evt <= 1'b0;
         err_evt   <= 1'b0;
      end else begin
         slave_evt <= (byte_done && dec_evt) || mack_evt;
         err_evt   <= drop_p;
      end
   end

   assign scl_drive_low = stretch_q;
   assign sda_drive_low = ack_drv_q | tx_drv_q;
endmodule

// File: rtl/i2c_addr_slave_chk.sv
module i2c_addr_slave_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       scl_lvl,
   input logic       start_c,
   input logic       stop_c,
   input logic       scl_free,
   input logic       scl_drive_low,
   input logic       sda_drive_low,
   input logic [7:0] rx_byte,
   input logic       rx_full,
   input logic       rx_take,
   input logic       overflow,
   input logic       slave_evt,
   input logic       err_evt
);
   p_sda_pull_scl_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_drive_low) |-> !scl_lvl);

   p_buffer_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_full && !rx_take |=> $stable(rx_byte));

   p_evt_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      slave_evt |=> !slave_evt);

   p_err_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      err_evt |=> !err_evt);

   p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      err_evt |-> overflow && rx_full);

   p_hold_until_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
      scl_drive_low && !scl_free && !start_c && !stop_c |=> scl_drive_low);

   p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stop_c |=> !scl_drive_low && !sda_drive_low);
endmodule

bind i2c_addr_slave i2c_addr_slave_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .scl_lvl       (scl_lvl),
   .start_c       (start_c),
   .stop_c        (stop_c),
   .scl_free      (scl_free),
   .scl_drive_low (scl_drive_low),
   .sda_drive_low (sda_drive_low),
   .rx_byte       (rx_byte),
   .rx_full       (rx_full),
   .rx_take       (rx_take),
   .overflow      (overflow),
   .slave_evt     (slave_evt),
   .err_evt       (err_evt)
);

// File: tb/i2c_addr_slave_test.sv
module i2c_addr_slave_test;
   localparam int Q = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       m_scl = 1'b1, m_sda = 1'b1;
   logic [9:0] own_addr = '0;
   logic       wide_mode = 1'b0;
   logic       scl_free = 1'b0;
   logic [7:0] tx_byte = '0;
   logic       rx_take = 1'b0;
   logic       scl_drive_low, sda_drive_low, rx_full, overflow, slave_evt, err_evt;
   logic [7:0] rx_byte;

   wire bus_scl = m_scl & ~scl_drive_low;
   wire bus_sda = m_sda & ~sda_drive_low;

   int total = 0, bad = 0, sevt = 0, eevt = 0;

   always #2.5 clk = ~clk;

   i2c_addr_slave uut (
      .clk (clk), .rst_n (rst_n), .scl_in (bus_scl), .sda_in (bus_sda),
      .scl_drive_low (scl_drive_low), .sda_drive_low (sda_drive_low),
      .own_addr (own_addr), .wide_mode (wide_mode), .scl_free (scl_free),
      .tx_byte (tx_byte), .rx_byte (rx_byte), .rx_full (rx_full),
      .rx_take (rx_take), .overflow (overflow), .slave_evt (slave_evt),
      .err_evt (err_evt)
   );

   always @(posedge clk) begin
      if (rst_n) begin
         if (slave_evt) sevt++;
         if (err_evt)   eevt++;
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic scl_up();
      m_scl = 1'b1;
      wait_cyc(1);
      while (bus_scl !== 1'b1) wait_cyc(1);
   endtask

   task automatic m_start();
      m_sda = 1'b1; wait_cyc(Q);
      scl_up();     wait_cyc(2*Q);
      m_sda = 1'b0; wait_cyc(2*Q);
      m_scl = 1'b0; wait_cyc(2*Q);
   endtask

   task automatic m_stop();
      m_sda = 1'b0; wait_cyc(Q);
      scl_up();     wait_cyc(2*Q);
      m_sda = 1'b1; wait_cyc(2*Q);
   endtask

   task automatic clock_bit(input logic b, output logic s);
      m_sda = b; wait_cyc(Q);
      scl_up();  wait_cyc(Q);
      s = bus_sda; wait_cyc(Q);
      m_scl = 1'b0; wait_cyc(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
      clock_bit(1'b1, s);
      ack = ~s;
      m_sda = 1'b1;
      wait_cyc(Q);
   endtask

   task automatic recv_byte(input logic mack, output logic [7:0] b);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         clock_bit(1'b1, s);
         b[i] = s;
      end
      clock_bit(~mack, s);
      m_sda = 1'b1;
      wait_cyc(Q);
   endtask

   task automatic pulse_free();
      scl_free = 1'b1; wait_cyc(1); scl_free = 1'b0; wait_cyc(2);
   endtask

   task automatic pulse_take();
      rx_take = 1'b1; wait_cyc(1); rx_take = 1'b0; wait_cyc(2);
   endtask

   task automatic t_reset();
      check("R10 scl pull after reset", scl_drive_low, 0);
      check("R10 sda pull after reset", sda_drive_low, 0);
      check("R10 rx_full after reset", rx_full, 0);
      check("R10 overflow after reset", overflow, 0);
      check("R10 event pulses after reset", {slave_evt, err_evt}, 0);
   endtask

   task automatic t_write7();
      logic a; int e0;
      own_addr = 10'h05A; wide_mode = 1'b0;
      m_start();
      e0 = sevt;
      send_byte(8'hB4, a);
      check("R1 7-bit write address ack", a, 1);
      check("R5 address match event", sevt - e0, 1);
      check("R7 no hold after write address", scl_drive_low, 0);
      send_byte(8'h3C, a);
      check("R4 data byte ack", a, 1);
      check("R4 rx_byte first", rx_byte, 8'h3C);
      check("R4 rx_full set", rx_full, 1);
      check("R5 byte copy event", sevt - e0, 2);
      check("R7 hold after received byte", scl_drive_low, 1);
      wait_cyc(60);
      check("R7 hold persists without free", bus_scl, 0);
      pulse_take();
      check("R6 take clears rx_full", rx_full, 0);
      pulse_free();
      check("R7 free ends hold", scl_drive_low, 0);
      send_byte(8'hC3, a);
      check("R4 second byte ack", a, 1);
      check("R4 rx_byte second", rx_byte, 8'hC3);
      pulse_take();
      pulse_free();
      m_stop();
      check("R9 stop releases lines", {scl_drive_low, sda_drive_low}, 0);
   endtask

   task automatic t_nomatch7();
      logic a; int e0;
      m_start();
      e0 = sevt;
      send_byte(8'hB6, a);
      check("R1 foreign address nack", a, 0);
      send_byte(8'h55, a);
      check("R1 data after foreign address ignored", a, 0);
      check("R1 buffer untouched when not addressed", rx_full, 0);
      check("R1 no event when not addressed", sevt - e0, 0);
      m_stop();
   endtask

   task automatic t_overflow();
      logic a; int x0;
      m_start();
      send_byte(8'hB4, a);
      send_byte(8'h11, a);
      pulse_free();
      x0 = eevt;
      send_byte(8'h22, a);
      check("R6 overflow byte nack", a, 0);
      check("R6 rx_byte keeps old", rx_byte, 8'h11);
      check("R6 overflow flag", overflow, 1);
      check("R6 error pulse", eevt - x0, 1);
      check("R7 no hold after dropped byte", scl_drive_low, 0);
      m_stop();
      pulse_take();
      check("R6 take clears overflow", {rx_full, overflow}, 0);
   endtask

   task automatic t_read7();
      logic a; logic [7:0] d; int e0;
      m_start();
      e0 = sevt;
      send_byte(8'hB5, a);
      check("R1 7-bit read address ack", a, 1);
      check("R7 hold before transmit", scl_drive_low, 1);
      tx_byte = 8'h9E;
      pulse_free();
      recv_byte(1'b1, d);
      check("R8 first transmitted byte", d, 8'h9E);
      check("R5 master ack event", sevt - e0, 2);
      check("R7 hold before next transmit", scl_drive_low, 1);
      tx_byte = 8'h41;
      pulse_free();
      recv_byte(1'b0, d);
      check("R8 second transmitted byte", d, 8'h41);
      check("R8 master nack ends transfer", {scl_drive_low, sda_drive_low}, 0);
      check("R5 no event on master nack", sevt - e0, 2);
      m_stop();
   endtask

   task automatic t_wide();
      logic a; logic [7:0] d; int e0;
      own_addr = 10'h2D3; wide_mode = 1'b1;
      m_start();
      e0 = sevt;
      send_byte(8'hF4, a);
      check("R2 10-bit header ack", a, 1);
      check("R2 no event before low byte", sevt - e0, 0);
      send_byte(8'hD3, a);
      check("R2 10-bit low byte ack", a, 1);
      check("R2 event after full match", sevt - e0, 1);
      send_byte(8'h77, a);
      check("R4 10-bit data byte", rx_byte, 8'h77);
      pulse_take();
      pulse_free();
      m_start();
      send_byte(8'hF5, a);
      check("R3 read header after match ack", a, 1);
      check("R7 hold before 10-bit transmit", scl_drive_low, 1);
      tx_byte = 8'h5C;
      pulse_free();
      recv_byte(1'b0, d);
      check("R8 10-bit transmitted byte", d, 8'h5C);
      m_stop();
      m_start();
      send_byte(8'hF5, a);
      check("R3 read header without match nack", a, 0);
      m_stop();
      m_start();
      e0 = sevt;
      send_byte(8'hF4, a);
      send_byte(8'hD2, a);
      check("R2 wrong low byte nack", a, 0);
      check("R2 no event on wrong low byte", sevt - e0, 0);
      m_stop();
   endtask

   task automatic t_free_idle();
      pulse_free();
      wait_cyc(5);
      check("R7 free while not holding has no effect", {scl_drive_low, sda_drive_low}, 0);
   endtask

   initial begin
      wait_cyc(5);
      rst_n = 1'b1;
      wait_cyc(5);
      t_reset();
      t_write7();
      t_nomatch7();
      t_overflow();
      t_read7();
      t_wide();
      t_free_idle();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule